// File: doc/BRIEF.md
# Floating-Point Coprocessor State Frame Engine

This block builds and walks the internal-state frames that a floating-point unit exchanges with memory when a context is saved or restored. A save request makes the engine write a frame of 32-bit words to a simple memory port. The frame's length and contents depend on the selected unit model. The words go either upward from the base address or, in predecrement addressing, downward below it. A restore request makes the engine read only the frame's first (header) word. It decodes that word to learn how large the frame is, and reports the address just past the frame so the caller can update its address register.

The engine is driven by a four-state machine. ST_IDLE waits for `start`. Then ST_SAVE (writing) or ST_LOAD (reading the header) runs, followed by a one-cycle ST_DONE. The transitions are: IDLE→SAVE on start with `save_op`=1, IDLE→LOAD on start with `save_op`=0, SAVE→DONE when the last word is accepted, LOAD→DONE when the header is accepted, and DONE→IDLE always. While `mem_ready` is low, the machine holds the current word in place.

Top module: `fsf_engine`

## Requirements
- R1: After reset, `mem_wr`, `mem_rd` and `done` are all low.
- R2: Model code 0 (three-word model) saves three words in frame order: 0x00006000, 0x00000000, 0x00000000.
- R3: Model code 1 (single-word model) saves one word: `version` in bits 31:24, zero elsewhere.
- R4: Model codes 2 and 3 (coprocessor models) save a header `version`<<24 | S<<16, with S = 0x18 for code 2 and 0x38 for code 3. It is followed by (S-1)/4 zero words (5 or 13) and a closing 0x70000000, so the frame is 7 or 15 words.
- R5: With `amode` other than 2, frame word k goes to `base_addr`+4k. A restore reads its header at `base_addr`. The final address is `base_addr` plus the frame length in bytes.
- R6: With `amode` = 2 (predecrement), the frame's words go out last-first. The t-th word written lands at `base_addr`-4(t+1), so the header ends at the lowest address. A restore reads its header at `base_addr`-4. The final address is `base_addr` minus the frame length.
- R7: One word moves per clock in which `mem_ready` is high. While `mem_ready` is low, address and data hold steady. Read and write are never requested together.
- R8: `done` is high for exactly one cycle, the cycle after the last word transfer.
- R9: A restore performs exactly one read. In model 0 it always treats the frame as 12 bytes, whatever the header holds.
- R10: In models 1 to 3, a header whose bits 31:24 are zero is a null frame of 4 bytes.
- R11: In coprocessor models, a non-null header's bits 23:16 give the frame length: 0x18→28 bytes, 0x38→60, 0xB4→184. Any other value gives 4.
- R12: In model 1, a non-null header's bits 23:16 give the frame length: 0x00→4 bytes, 0x30→48, 0x60→96. Any other value gives 4.
- R13: `wb_en` is high alongside `done` only when `amode` is 1 (postincrement) or 2 (predecrement). For codes 0 and 3 it stays low, although `final_addr` is still reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins an operation when idle |
| save_op | input | 1 | 1 = save frame, 0 = restore frame |
| model | input | 2 | Unit model code (0 three-word, 1 single-word, 2/3 coprocessor small/large) |
| amode | input | 2 | Addressing mode (0 plain, 1 postincrement, 2 predecrement, 3 displacement) |
| version | input | 8 | Version code placed in headers |
| base_addr | input | ADDR_W | Effective address of the operation |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wr | output | 1 | Write request |
| mem_rd | output | 1 | Read request |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory accepts the current request |
| done | output | 1 | One-cycle completion pulse |
| final_addr | output | ADDR_W | Address past the frame, valid with `done` |
| wb_en | output | 1 | Address register writeback enable, valid with `done` |

## Verification
Assertions check on every cycle that a stalled write holds its address and data, and that consecutive writes step by exactly one word. They also check that read and write never coincide, that a restore issues one read, that `done` never lasts two cycles, and that `wb_en` only accompanies `done` in the two updating modes. The frame contents, the reverse ordering in predecrement, the header decode for every size and type code, null frames and the final addresses can only be shown by the bench. It compares each transfer and result with values it computes itself, under both directed and random stall patterns.

// File: rtl/fsf_pkg.sv
package fsf_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        MDL_TRIPLE  = 2'd0,
        MDL_WORD    = 2'd1,
        MDL_COPRO_S = 2'd2,
        MDL_COPRO_L = 2'd3
    } fsf_model_e;

    typedef enum logic [1:0] {
        AM_PLAIN   = 2'd0,
        AM_POSTINC = 2'd1,
        AM_PREDEC  = 2'd2,
        AM_DISP    = 2'd3
    } fsf_amode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SAVE,
        ST_LOAD,
        ST_DONE
    } fsf_state_e;

    localparam logic [WORD_W-1:0] TRIPLE_HDR = 32'h0000_6000;
    localparam logic [WORD_W-1:0] TAIL_WORD  = 32'h7000_0000;
    localparam logic [7:0] SZ_SMALL = 8'h18;
    localparam logic [7:0] SZ_LARGE = 8'h38;
    localparam logic [7:0] SZ_HUGE  = 8'hB4;
    localparam logic [7:0] TY_IDLE  = 8'h00;
    localparam logic [7:0] TY_UNIMP = 8'h30;
    localparam logic [7:0] TY_BUSY  = 8'h60;
    localparam int HDR_BYTES    = 4;
    localparam int TRIPLE_BYTES = 12;
    localparam int SKIP_UNIMP   = 44;
    localparam int SKIP_BUSY    = 92;
endpackage

// File: rtl/fsf_save_layout.sv
module fsf_save_layout
    import fsf_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic [1:0]        model,
    input  logic [7:0]        version,
    input  logic [CNT_W-1:0]  idx,
    output logic [CNT_W-1:0]  nwords,
    output logic [WORD_W-1:0] word
);
    logic [7:0] sz;

    always_comb begin
        nwords = '0;
        word   = '0;
        sz     = (fsf_model_e'(model) == MDL_COPRO_L) ? SZ_LARGE : SZ_SMALL;
        unique case (fsf_model_e'(model))
            MDL_TRIPLE: begin
                nwords = CNT_W'(3);
                if (idx == '0) word = TRIPLE_HDR;
            end
            MDL_WORD: begin
                nwords = CNT_W'(1);
                word   = {version, 24'h0};
            end
            MDL_COPRO_S, MDL_COPRO_L: begin
                nwords = CNT_W'(((sz - 8'd1) >> 2) + 8'd2);
                if (idx == '0)
                    word = {version, sz, 16'h0};
                else if (idx == nwords - 1'b1)
                    word = TAIL_WORD;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fsf_restore_span.sv
module fsf_restore_span
    import fsf_pkg::*;
#(
    parameter int SPAN_W = 9
) (
    input  logic [1:0]        model,
    input  logic [15:0]       hdr_hi,
    output logic [SPAN_W-1:0] span
);
    logic [7:0] ver_f;
    logic [7:0] code_f;

    assign ver_f  = hdr_hi[15:8];
    assign code_f = hdr_hi[7:0];

    always_comb begin
        span = SPAN_W'(HDR_BYTES);
        if (fsf_model_e'(model) == MDL_TRIPLE) begin
            span = SPAN_W'(TRIPLE_BYTES);
        end else if (ver_f != 8'h00) begin
            if (fsf_model_e'(model) == MDL_WORD) begin
                if (code_f == TY_UNIMP)
                    span = SPAN_W'(HDR_BYTES + SKIP_UNIMP);
                else if (code_f == TY_BUSY)
                    span = SPAN_W'(HDR_BYTES + SKIP_BUSY);
            end else if (code_f == SZ_SMALL || code_f == SZ_LARGE || code_f == SZ_HUGE) begin
                span = SPAN_W'(HDR_BYTES) + SPAN_W'(code_f);
            end
        end
    end
endmodule

// File: rtl/fsf_addr_step.sv
module fsf_addr_step #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic              down,
    input  logic [ADDR_W-1:0] off,
    output logic [ADDR_W-1:0] addr
);
    assign addr = down ? (base - off) : (base + off);
endmodule

// File: rtl/fsf_engine.sv
module fsf_engine
    import fsf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 4,
    parameter int SPAN_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              save_op,
    input  logic [1:0]        model,
    input  logic [1:0]        amode,
    input  logic [7:0]        version,
    input  logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              done,
    output logic [ADDR_W-1:0] final_addr,
    output logic              wb_en
);
    fsf_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              save_q;
    logic [1:0]        model_q;
    fsf_amode_e        amode_q;
    logic [7:0]        version_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] final_q;
    logic              wb_q;

    logic              predec;
    logic [CNT_W-1:0]  nwords;
    logic [CNT_W-1:0]  idx;
    logic              last_word;
    logic [SPAN_W-1:0] span;
    logic [ADDR_W-1:0] slot;
    logic [ADDR_W-1:0] off_mem;
    logic [ADDR_W-1:0] off_fin;
    logic [ADDR_W-1:0] fin_addr;
    logic              finish;

    assign predec    = (amode_q == AM_PREDEC);
    assign idx       = predec ? (nwords - 1'b1 - cnt_q) : cnt_q;
    assign last_word = (cnt_q == nwords - 1'b1);
    assign slot      = ADDR_W'(cnt_q) + (predec ? ADDR_W'(1) : '0);
    assign off_mem   = slot << 2;
    assign off_fin   = save_q ? (ADDR_W'(nwords) << 2) : ADDR_W'(span);
    assign finish    = mem_ready && ((state_q == ST_SAVE && last_word) || state_q == ST_LOAD);

    fsf_save_layout #(.CNT_W(CNT_W)) u_layout (
        .model   (model_q),
        .version (version_q),
        .idx     (idx),
        .nwords  (nwords),
        .word    (mem_wdata)
    );

    fsf_restore_span #(.SPAN_W(SPAN_W)) u_span (
        .model  (model_q),
        .hdr_hi (mem_rdata[31:16]),
        .span   (span)
    );

    fsf_addr_step #(.ADDR_W(ADDR_W)) u_step_mem (
        .base (base_q),
        .down (predec),
        .off  (off_mem),
        .addr (mem_addr)
    );

    fsf_addr_step #(.ADDR_W(ADDR_W)) u_step_fin (
        .base (base_q),
        .down (predec),
        .off  (off_fin),
        .addr (fin_addr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = save_op ? ST_SAVE : ST_LOAD;
            ST_SAVE: if (mem_ready && last_word) state_d = ST_DONE;
            ST_LOAD: if (mem_ready) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // operation context and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            save_q    <= 1'b0;
            model_q   <= '0;
            amode_q   <= AM_PLAIN;
            version_q <= '0;
            base_q    <= '0;
            final_q   <= '0;
            wb_q      <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                save_q    <= save_op;
                model_q   <= model;
                amode_q   <= fsf_amode_e'(amode);
                version_q <= version;
                base_q    <= base_addr;
                cnt_q     <= '0;
            end
            if (state_q == ST_SAVE && mem_ready)
                cnt_q <= cnt_q + 1'b1;
            if (finish) begin
                final_q <= fin_addr;
                wb_q    <= (amode_q == AM_POSTINC) || (amode_q == AM_PREDEC);
            end
        end
    end

    // outputs
    always_comb begin
        mem_wr = 1'b0;
        mem_rd = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SAVE: mem_wr = 1'b1;
            ST_LOAD: mem_rd = 1'b1;
            ST_DONE: done   = 1'b1;
            default: ;
        endcase
    end

    assign final_addr = final_q;
    assign wb_en      = done && wb_q;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata))); // R7
    AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && mem_rd)); // R7
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(mem_wr && mem_ready)) |->
        (mem_addr == $past(mem_addr) + ADDR_W'(4) || mem_addr == $past(mem_addr) - ADDR_W'(4))); // R5
    AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_ready) |=> !mem_rd); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_WB_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (done && (amode_q == AM_POSTINC || amode_q == AM_PREDEC))); // R13
endmodule

// File: tb/tb_fsf_engine.sv
`timescale 1ns/1ps
module tb_fsf_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        save_op = 1'b0;
    logic [1:0]  model = '0;
    logic [1:0]  amode = '0;
    logic [7:0]  version = '0;
    logic [31:0] base_addr = '0;
    logic [31:0] mem_addr;
    logic        mem_wr;
    logic        mem_rd;
    logic [31:0] mem_wdata;
    logic [31:0] hdr_word = '0;
    logic        mem_ready = 1'b1;
    logic        done;
    logic [31:0] final_addr;
    logic        wb_en;
    logic        rdy_force = 1'b1;

    always #4 clk = ~clk;

    fsf_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .save_op(save_op),
        .model(model), .amode(amode), .version(version), .base_addr(base_addr),
        .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_wdata(mem_wdata),
        .mem_rdata(hdr_word), .mem_ready(mem_ready), .done(done),
        .final_addr(final_addr), .wb_en(wb_en)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [31:0] cap_a [0:31];
    logic [31:0] cap_d [0:31];
    int ncap, nrd, ndone, wr_smp, smp, last_x, gap;
    logic [31:0] rd_a, fin;
    logic wb;

    always @(posedge clk) begin
        #1;
        mem_ready = rdy_force ? 1'b1 : (($urandom % 3) != 0);
    end

    always @(negedge clk) begin
        smp++;
        if (mem_wr) wr_smp++;
        if (mem_wr && mem_ready) begin
            if (ncap < 32) begin
                cap_a[ncap] = mem_addr;
                cap_d[ncap] = mem_wdata;
            end
            ncap++;
            last_x = smp;
        end
        if (mem_rd && mem_ready) begin
            nrd++;
            rd_a = mem_addr;
            last_x = smp;
        end
        if (done) begin
            ndone++;
            fin = final_addr;
            wb = wb_en;
            gap = smp - last_x;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not end, actual=%0d expected<=150000 cycles", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int exp_n(input logic [1:0] m);
        case (m)
            2'd0: return 3;
            2'd1: return 1;
            2'd2: return 7;
            default: return 15;
        endcase
    endfunction

    function automatic logic [31:0] exp_word(input logic [1:0] m, input logic [7:0] v, input int k);
        case (m)
            2'd0: return (k == 0) ? 32'h0000_6000 : 32'h0;
            2'd1: return {v, 24'h0};
            default: begin
                if (k == 0) return {v, (m == 2'd2) ? 8'h18 : 8'h38, 16'h0};
                if (k == exp_n(m) - 1) return 32'h7000_0000;
                return 32'h0;
            end
        endcase
    endfunction

    function automatic int exp_span(input logic [1:0] m, input logic [31:0] h);
        if (m == 2'd0) return 12;
        if (h[31:24] == 8'h0) return 4;
        if (m == 2'd1) begin
            if (h[23:16] == 8'h30) return 48;
            if (h[23:16] == 8'h60) return 96;
            return 4;
        end
        if (h[23:16] == 8'h18) return 28;
        if (h[23:16] == 8'h38) return 60;
        if (h[23:16] == 8'hB4) return 184;
        return 4;
    endfunction

    task automatic run_op(input bit sv, input logic [1:0] m, input logic [1:0] am,
                          input logic [7:0] v, input logic [31:0] b, input logic [31:0] h);
        bit pd;
        int n, len;
        string tw, ta, tr;
        logic [31:0] ea, ef;
        ncap = 0; nrd = 0; ndone = 0; wr_smp = 0; gap = -1;
        save_op = sv; model = m; amode = am; version = v; base_addr = b; hdr_word = h;
        @(posedge clk); #2 start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
        for (int i = 0; i < 500 && ndone == 0; i++) @(posedge clk);
        repeat (3) @(posedge clk);
        pd = (am == 2'd2);
        ta = pd ? "R6" : "R5";
        if (sv) begin
            n = exp_n(m);
            tw = (m == 2'd0) ? "R2" : (m == 2'd1) ? "R3" : "R4";
            chk(ncap == n, {tw, " word count"}, ncap, n);
            for (int j = 0; j < n && j < ncap; j++) begin
                int k = pd ? (n - 1 - j) : j;
                ea = pd ? (b - 32'(4 * (j + 1))) : (b + 32'(4 * j));
                chk(cap_d[j] == exp_word(m, v, k), {tw, " word data"}, cap_d[j], exp_word(m, v, k));
                chk(cap_a[j] == ea, {ta, " word address"}, cap_a[j], ea);
            end
            if (rdy_force) chk(wr_smp == n, "R7 one word per ready cycle", wr_smp, n);
            len = 4 * n;
        end else begin
            len = exp_span(m, h);
            tr = (m == 2'd0) ? "R9" : (h[31:24] == 8'h0) ? "R10" : (m == 2'd1) ? "R12" : "R11";
            chk(nrd == 1, "R9 single header read", nrd, 1);
            ea = pd ? (b - 32'd4) : b;
            chk(rd_a == ea, {ta, " header address"}, rd_a, ea);
            ef = pd ? (b - 32'(len)) : (b + 32'(len));
            chk(fin == ef, {tr, " restore final address"}, fin, ef);
        end
        ef = pd ? (b - 32'(len)) : (b + 32'(len));
        if (sv) chk(fin == ef, {ta, " save final address"}, fin, ef);
        chk(wb == (am == 2'd1 || am == 2'd2), "R13 writeback enable", wb, (am == 2'd1 || am == 2'd2));
        chk(ndone == 1, "R8 done pulse count", ndone, 1);
        chk(gap == 1, "R8 done follows last transfer", gap, 1);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5EED_1234);
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_wr && !mem_rd && !done, "R1 quiet after reset", {mem_wr, mem_rd, done}, 0);

        // directed saves, every model, both directions
        for (int m = 0; m < 4; m++) begin
            run_op(1'b1, 2'(m), 2'd1, 8'h1F, 32'h0000_4000, 32'h0);
            run_op(1'b1, 2'(m), 2'd2, 8'h41, 32'h0000_8000, 32'h0);
        end
        run_op(1'b1, 2'd3, 2'd0, 8'h20, 32'h0000_2000, 32'h0);   // R13 plain mode
        // directed restores
        run_op(1'b0, 2'd0, 2'd1, 8'h0, 32'h0000_1000, 32'h0000_0000); // R9 null ignored in triple
        run_op(1'b0, 2'd0, 2'd2, 8'h0, 32'h0000_1000, 32'h1F38_0000); // R9
        run_op(1'b0, 2'd1, 2'd1, 8'h0, 32'h0000_1000, 32'h0030_0000); // R10 null
        run_op(1'b0, 2'd2, 2'd2, 8'h0, 32'h0000_1000, 32'h00B4_0000); // R10 null
        run_op(1'b0, 2'd1, 2'd1, 8'h0, 32'h0000_1000, 32'h4100_0000); // R12 idle
        run_op(1'b0, 2'd1, 2'd2, 8'h0, 32'h0000_1000, 32'h4130_0000); // R12 unimp
        run_op(1'b0, 2'd1, 2'd1, 8'h0, 32'h0000_1000, 32'h4160_0000); // R12 busy
        run_op(1'b0, 2'd1, 2'd1, 8'h0, 32'h0000_1000, 32'h4118_0000); // R12 unknown
        run_op(1'b0, 2'd2, 2'd1, 8'h0, 32'h0000_1000, 32'h1F18_0000); // R11
        run_op(1'b0, 2'd3, 2'd2, 8'h0, 32'h0000_1000, 32'h2038_0000); // R11
        run_op(1'b0, 2'd2, 2'd1, 8'h0, 32'h0000_1000, 32'h1FB4_0000); // R11
        run_op(1'b0, 2'd3, 2'd3, 8'h0, 32'h0000_1000, 32'h2060_0000); // R11 unknown, R13

        // random mix with random stalls
        rdy_force = 1'b0;
        for (int t = 0; t < 60; t++) begin
            logic [31:0] h;
            logic [7:0] v;
            v = 8'($urandom) | 8'h01;
            case ($urandom % 8)
                0: h = {v, 8'h18, 16'($urandom)};
                1: h = {v, 8'h38, 16'($urandom)};
                2: h = {v, 8'hB4, 16'($urandom)};
                3: h = {v, 8'h00, 16'($urandom)};
                4: h = {v, 8'h30, 16'($urandom)};
                5: h = {v, 8'h60, 16'($urandom)};
                6: h = {8'h00, 24'($urandom)};
                default: h = $urandom;
            endcase
            run_op(1'($urandom), 2'($urandom), 2'($urandom), v,
                   32'h0010_0000 + ($urandom & 32'h0000_FFFC), h);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule